// File: doc/BRIEF.md
# Cascaded Two-Input Lookup Tree

This block is a purely combinational logic element made from small lookup tables of two inputs each. Every table carries its own 4-bit truth value, supplied on a port of its own, and the tables are wired into a fixed tree. A build-time parameter selects one of three shapes:

- a lone table over two data pins;
- a four-pin tree, where two leaf tables feed a joining table;
- a five-pin tree, where that four-pin tree feeds the second side of an apex table whose first side is the fifth pin.

Wide functions are formed by programming each table separately, not by one wide table. A user writes AND, OR, XOR, pass-through or inverted-input variants into each node. The composed result then appears on the single output in the same evaluation as the input change.

Top module: `lut2_tree`

## Requirements
- R1: Each table outputs bit `{b, a}` of its 4-bit truth value, where `a` is its first input and forms the index LSB. For example, truth value 4'b0010 gives 1 only for a=1, b=0.
- R2: With FANIN=2, `dout` equals `tt_lo` indexed by {din[1], din[0]}. The pins din[4:2] and the ports `tt_hi`, `tt_mid` and `tt_apex` have no effect on `dout`.
- R3: With FANIN=4, the low leaf reads (din[0], din[1]) and the high leaf reads (din[2], din[3]). The joining table `tt_mid` takes the low leaf as its first input and the high leaf as its second. `dout` is the joining table's output, and din[4] and `tt_apex` have no effect on it.
- R4: With FANIN=5, the four-pin tree of R3 feeds the second input of the apex table `tt_apex`, and din[4] is its first input. `dout` is the apex output.
- R5: Truth value 4'b1000 yields the AND of a table's two inputs, 4'b1110 yields the OR, and 4'b0110 yields the XOR.
- R6: Truth value 4'b1010 passes a table's first input through unchanged.
- R7: Truth value 4'b0000 makes a table drive constant 0. If every table holds zero, `dout` is 0.
- R8: Flipping one index bit of every set bit in a truth value inverts the matching input. For example, 4'b0100 yields (NOT a) AND b.
- R9: The block holds no state: `dout` follows any change of a data pin or a truth value without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 5 | Data pins; bit k is pin k |
| tt_lo | input | 4 | Truth value of the low leaf (the only table when FANIN=2) |
| tt_hi | input | 4 | Truth value of the high leaf |
| tt_mid | input | 4 | Truth value of the table joining the two leaves |
| tt_apex | input | 4 | Truth value of the apex table (FANIN=5 only) |
| dout | output | 1 | Result of the tree |

## Verification
The bench builds the block three times, with FANIN set to 5, 4 and 2, and drives all three copies from the same pins and truth values. For each copy, all 32 pin combinations are applied under every assignment of AND, OR, XOR, pass-through, inverted-input AND and zero to the four truth ports. The smaller copies are therefore exposed to active pins and truth values that they must ignore. Named cases pin down index order, the single-bit selection of R1, inversion and the all-zero state.

// File: rtl/lut_tree_pkg.sv
package lut_tree_pkg;
    localparam int unsigned TT_W   = 4;
    localparam int unsigned MAX_IN = 5;

    typedef logic [TT_W-1:0] tt_t;

    typedef enum logic [1:0] {
        SHAPE_SINGLE = 2'd0,
        SHAPE_QUAD   = 2'd1,
        SHAPE_PENTA  = 2'd2
    } shape_e;

    function automatic shape_e shape_of(input int unsigned fanin);
        if (fanin == 2) return SHAPE_SINGLE;
        if (fanin == 4) return SHAPE_QUAD;
        return SHAPE_PENTA;
    endfunction

    typedef struct packed {
        logic lo;
        logic hi;
        logic mid;
        logic apex;
    } node_t;
endpackage

// File: rtl/lut2_cell.sv
module lut2_cell
    import lut_tree_pkg::*;
(
    input  tt_t  truth,
    input  logic in_a,
    input  logic in_b,
    output logic y
);
    logic [1:0] idx;

    always_comb begin
        idx = {in_b, in_a};
        y   = truth[idx];
    end
endmodule

// File: rtl/lut2_quad.sv
module lut2_quad
    import lut_tree_pkg::*;
(
    input  logic [3:0] pins,
    input  tt_t        tt_lo,
    input  tt_t        tt_hi,
    input  tt_t        tt_mid,
    output logic       leaf_lo,
    output logic       leaf_hi,
    output logic       y
);
    lut2_cell u_lo (
        .truth (tt_lo),
        .in_a  (pins[0]),
        .in_b  (pins[1]),
        .y     (leaf_lo)
    );

    lut2_cell u_hi (
        .truth (tt_hi),
        .in_a  (pins[2]),
        .in_b  (pins[3]),
        .y     (leaf_hi)
    );

    lut2_cell u_mid (
        .truth (tt_mid),
        .in_a  (leaf_lo),
        .in_b  (leaf_hi),
        .y     (y)
    );
endmodule

// File: rtl/lut2_tree.sv
module lut2_tree
    import lut_tree_pkg::*;
#(
    parameter int unsigned FANIN = 5
) (
    input  logic [4:0] din,
    input  logic [3:0] tt_lo,
    input  logic [3:0] tt_hi,
    input  logic [3:0] tt_mid,
    input  logic [3:0] tt_apex,
    output logic       dout
);
    localparam shape_e SHAPE = shape_of(FANIN);

    node_t nodes_d;

    generate
        if (SHAPE == SHAPE_SINGLE) begin : g_single
            logic lo_y;
            logic unused_pins;
            assign unused_pins = ^{din[4:2], tt_hi, tt_mid, tt_apex};
            lut2_cell u_only (
                .truth (tt_lo),
                .in_a  (din[0]),
                .in_b  (din[1]),
                .y     (lo_y)
            );
            always_comb begin
                nodes_d      = '0;
                nodes_d.lo   = lo_y;
                nodes_d.apex = lo_y;
            end
        end else if (SHAPE == SHAPE_QUAD) begin : g_quad
            logic lo_y, hi_y, mid_y;
            logic unused_pins;
            assign unused_pins = ^{din[4], tt_apex};
            lut2_quad u_quad (
                .pins    (din[3:0]),
                .tt_lo   (tt_lo),
                .tt_hi   (tt_hi),
                .tt_mid  (tt_mid),
                .leaf_lo (lo_y),
                .leaf_hi (hi_y),
                .y       (mid_y)
            );
            always_comb begin
                nodes_d      = '0;
                nodes_d.lo   = lo_y;
                nodes_d.hi   = hi_y;
                nodes_d.mid  = mid_y;
                nodes_d.apex = mid_y;
            end
        end else begin : g_penta
            logic lo_y, hi_y, mid_y, apex_y;
            lut2_quad u_quad (
                .pins    (din[3:0]),
                .tt_lo   (tt_lo),
                .tt_hi   (tt_hi),
                .tt_mid  (tt_mid),
                .leaf_lo (lo_y),
                .leaf_hi (hi_y),
                .y       (mid_y)
            );
            lut2_cell u_apex (
                .truth (tt_apex),
                .in_a  (din[4]),
                .in_b  (mid_y),
                .y     (apex_y)
            );
            always_comb begin
                nodes_d.lo   = lo_y;
                nodes_d.hi   = hi_y;
                nodes_d.mid  = mid_y;
                nodes_d.apex = apex_y;
            end
        end
    endgenerate

    assign dout = nodes_d.apex;
endmodule

// File: rtl/lut2_tree_chk.sv
module lut2_tree_chk #(
    parameter int unsigned FANIN = 5
) (
    input logic [4:0] din,
    input logic [3:0] tt_lo,
    input logic [3:0] tt_hi,
    input logic [3:0] tt_mid,
    input logic [3:0] tt_apex,
    input logic       dout
);
    logic [3:0] root_tt;
    logic       all_zero, all_xor, all_route, parity;

    always_comb begin
        if (FANIN == 2) begin
            root_tt   = tt_lo;
            all_zero  = (tt_lo == 4'b0000);
            all_xor   = (tt_lo == 4'b0110);
            all_route = (tt_lo == 4'b1010);
            parity    = din[0] ^ din[1];
        end else if (FANIN == 4) begin
            root_tt   = tt_mid;
            all_zero  = (tt_lo == 4'b0000) && (tt_hi == 4'b0000) && (tt_mid == 4'b0000);
            all_xor   = (tt_lo == 4'b0110) && (tt_hi == 4'b0110) && (tt_mid == 4'b0110);
            all_route = (tt_lo == 4'b1010) && (tt_mid == 4'b1010);
            parity    = ^din[3:0];
        end else begin
            root_tt   = tt_apex;
            all_zero  = (tt_lo == 4'b0000) && (tt_hi == 4'b0000) &&
                        (tt_mid == 4'b0000) && (tt_apex == 4'b0000);
            all_xor   = (tt_lo == 4'b0110) && (tt_hi == 4'b0110) &&
                        (tt_mid == 4'b0110) && (tt_apex == 4'b0110);
            all_route = (tt_apex == 4'b1010) && (tt_mid == 4'b1010) && (tt_lo == 4'b1010);
            parity    = ^din;
        end
    end

    always_comb begin
        if (root_tt == 4'b0000)
            p_root_zero_r7: assert (dout == 1'b0);
        if (all_zero)
            p_all_zero_r7: assert (dout == 1'b0);
        if (root_tt == 4'b1111)
            p_root_one_r1: assert (dout == 1'b1);
        if (all_xor)
            p_xor_chain_r5: assert (dout == parity);
        if (all_route)
            p_route_path_r6: assert (dout == ((FANIN == 5) ? din[4] : din[0]));
    end
endmodule

bind lut2_tree lut2_tree_chk #(.FANIN(FANIN)) u_chk (
    .din     (din),
    .tt_lo   (tt_lo),
    .tt_hi   (tt_hi),
    .tt_mid  (tt_mid),
    .tt_apex (tt_apex),
    .dout    (dout)
);

// File: tb/tb_lut2_tree.sv
module tb_lut2_tree;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic [4:0] din = '0;
    logic [3:0] tt_lo = '0, tt_hi = '0, tt_mid = '0, tt_apex = '0;
    logic       o5, o4, o2;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut2_tree #(.FANIN(5)) dut (
        .din (din), .tt_lo (tt_lo), .tt_hi (tt_hi), .tt_mid (tt_mid),
        .tt_apex (tt_apex), .dout (o5));
    lut2_tree #(.FANIN(4)) dut_q (
        .din (din), .tt_lo (tt_lo), .tt_hi (tt_hi), .tt_mid (tt_mid),
        .tt_apex (tt_apex), .dout (o4));
    lut2_tree #(.FANIN(2)) dut_s (
        .din (din), .tt_lo (tt_lo), .tt_hi (tt_hi), .tt_mid (tt_mid),
        .tt_apex (tt_apex), .dout (o2));

    function automatic logic ref2(input logic [3:0] tt, input logic a, input logic b);
        int k;
        k = 2 * int'(b) + int'(a);
        return logic'((tt >> k) & 4'd1);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: din=%b tt=%b/%b/%b/%b actual=%b expected=%b",
                     req, din, tt_lo, tt_hi, tt_mid, tt_apex, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] lo, input logic [3:0] hi,
                         input logic [3:0] mid, input logic [3:0] ap, input logic [4:0] d);
        tt_lo = lo; tt_hi = hi; tt_mid = mid; tt_apex = ap; din = d;
        #1;
    endtask

    logic [3:0] pats [6];

    initial begin
        pats[0] = 4'b1000; pats[1] = 4'b1110; pats[2] = 4'b0110;
        pats[3] = 4'b1010; pats[4] = 4'b0100; pats[5] = 4'b0000;

        // R7: idle state, every table zero
        apply(4'b0000, 4'b0000, 4'b0000, 4'b0000, 5'b11111);
        check("R7", o5, 1'b0); check("R7", o4, 1'b0); check("R7", o2, 1'b0);

        // R1: single set bit selects a=1, b=0 only
        apply(4'b0010, 4'b0, 4'b0, 4'b0, 5'b00001); check("R1", o2, 1'b1);
        apply(4'b0010, 4'b0, 4'b0, 4'b0, 5'b00010); check("R1", o2, 1'b0);
        apply(4'b0010, 4'b0, 4'b0, 4'b0, 5'b00011); check("R1", o2, 1'b0);

        // R5: AND / OR / XOR across the five-pin tree
        apply(4'b1000, 4'b1000, 4'b1000, 4'b1000, 5'b11111); check("R5", o5, 1'b1);
        apply(4'b1000, 4'b1000, 4'b1000, 4'b1000, 5'b01111); check("R5", o5, 1'b0);
        apply(4'b1110, 4'b1110, 4'b1110, 4'b1110, 5'b00000); check("R5", o5, 1'b0);
        apply(4'b1110, 4'b1110, 4'b1110, 4'b1110, 5'b00100); check("R5", o5, 1'b1);
        apply(4'b0110, 4'b0110, 4'b0110, 4'b0110, 5'b10110); check("R5", o5, 1'b1);

        // R6: apex pass-through shows pin 4
        apply(4'b0000, 4'b0000, 4'b0000, 4'b1010, 5'b10000); check("R6", o5, 1'b1);
        apply(4'b1110, 4'b1110, 4'b1110, 4'b1010, 5'b01111); check("R6", o5, 1'b0);

        // R8: inverted first input
        apply(4'b0100, 4'b0, 4'b0, 4'b0, 5'b00010); check("R8", o2, 1'b1);
        apply(4'b0100, 4'b0, 4'b0, 4'b0, 5'b00011); check("R8", o2, 1'b0);

        // R9: output follows a pin change with no clock edge
        apply(4'b1010, 4'b0, 4'b1010, 4'b0, 5'b00000); check("R9", o4, 1'b0);
        din = 5'b00001; #1; check("R9", o4, 1'b1);

        // R2, R3, R4: exhaustive sweep over patterns and pins
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int c = 0; c < 6; c++)
                    for (int e = 0; e < 6; e++)
                        for (int v = 0; v < 32; v++) begin
                            logic [4:0] dv;
                            logic lo_r, hi_r, mid_r, ap_r;
                            dv = v[4:0];
                            apply(pats[a], pats[b], pats[c], pats[e], dv);
                            lo_r  = ref2(pats[a], dv[0], dv[1]);
                            hi_r  = ref2(pats[b], dv[2], dv[3]);
                            mid_r = ref2(pats[c], lo_r, hi_r);
                            ap_r  = ref2(pats[e], dv[4], mid_r);
                            check("R4", o5, ap_r);
                            check("R3", o4, mid_r);
                            check("R2", o2, lo_r);
                        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < WATCHDOG; k++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule